// File: doc/BRIEF.md
# Processor Status Word Control Unit

This block owns a 32-bit processor status word and applies status-changing commands to it, one command per clock. It holds the condition-flag bits in their own register, apart from the rest of the state. The `status_word` output always shows the two registers combined. The `rd_data` output gives a read view of that word through a fixed visibility mask.

A command is presented with `op_valid` high and chosen by `op_sel`. The byte-lane write replaces the lanes picked by `byte_en` with the matching lanes of `wr_data`. The change-state command decodes a 10-bit immediate. It can clear or set the F, I and A mask bits and can switch the mode field, but it does nothing while the current mode is user. The endianness command copies one immediate bit into the E field. The `nmfi_cfg` input stops the disable path from setting F. Every update appears on the clock edge that samples the command.

Top module: `psr_ctrl_unit`

## Requirements
- R1: Synchronous active-high reset loads 0x000001D3 into the status word: mode 5'b10011, with A (bit 8), I (bit 7) and F (bit 6) set and every other bit clear.
- R2: `rd_data` always equals the combined status word ANDed with 0xF8FF03DF.
- R3: The change-state command (`op_sel` = 2'b01) leaves the status word unchanged when the current mode field (bits 4:0) is the user encoding 5'b10000. The check uses the mode held before the command.
- R4: A change-state command with imm[9]=1 clears each selected mask bit: imm[5] selects F (bit 6), imm[6] selects I (bit 7) and imm[7] selects A (bit 8). `nmfi_cfg` has no effect on this path.
- R5: A change-state command with imm[9]=0 sets the selected I and A bits. It sets a selected F only while `nmfi_cfg` is 0; with `nmfi_cfg` at 1, F keeps its value.
- R6: A change-state command loads imm[4:0] into the mode field only when imm[8] is 1. Otherwise the mode field keeps its value.
- R7: The write command (`op_sel` = 2'b00) replaces byte lane k (bits 8k+7:8k) with the same lane of `wr_data` when `byte_en[k]` is 1, and keeps the other lanes. It is not gated by mode.
- R8: The condition-flag bits (mask 0xF80F0000) are stored separately. Only the write command changes them; change-state and endianness commands leave them unchanged.
- R9: The endianness command (`op_sel` = 2'b10) copies imm[0] into bit 9 (E) in any mode and leaves every other bit unchanged.
- R10: The status word stays the same when `op_valid` is 0 or when `op_sel` is the reserved code 2'b11. A valid command's result shows on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A command is present this cycle |
| op_sel | input | 2 | Command: 00 write, 01 change-state, 10 endianness, 11 reserved |
| imm | input | 10 | Immediate for the change-state and endianness commands |
| wr_data | input | 32 | Write operand for the byte-lane write |
| byte_en | input | 4 | Lane enables for the write, one bit per byte |
| nmfi_cfg | input | 1 | When 1, the disable path may not set F |
| status_word | output | 32 | Combined status word (flags and main state) |
| rd_data | output | 32 | Masked read view of the status word |

## Verification
One change-state command can both move a mask bit and switch the mode. The critical case is a command that disables A and moves the mode to user in the same cycle. The bench issues that command from a privileged mode and expects both effects, because gating must use the mode held before the command. A follow-up change-state command in user mode must then leave the word untouched. The bench also checks that an endianness command and a byte write still take effect while the mode is user.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int WORD_W  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = WORD_W / LANE_W;
    localparam int MODE_W  = 5;
    localparam int IMM_W   = 10;

    // bit positions inside the status word
    localparam int POS_F   = 6;
    localparam int POS_I   = 7;
    localparam int POS_A   = 8;
    localparam int POS_E   = 9;

    localparam logic [WORD_W-1:0] FLAG_MASK = 32'hF80F_0000;
    localparam logic [WORD_W-1:0] READ_MASK = 32'hF8FF_03DF;

    localparam logic [MODE_W-1:0] MODE_USER  = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_RESET = 5'b10011;

    typedef enum logic [1:0] {
        OP_WRITE    = 2'b00,
        OP_CHGSTATE = 2'b01,
        OP_ENDIAN   = 2'b10,
        OP_RSVD     = 2'b11
    } psr_op_e;

    // field order follows the immediate bit order (9 down to 0)
    typedef struct packed {
        logic              enable;
        logic              set_mode;
        logic              sel_a;
        logic              sel_i;
        logic              sel_f;
        logic [MODE_W-1:0] mode;
    } chg_cmd_t;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] main;
    } psr_state_t;

    function automatic logic mode_is_user(input logic [WORD_W-1:0] word);
        return word[MODE_W-1:0] == MODE_USER;
    endfunction

    function automatic logic [WORD_W-1:0] reset_word(input logic [MODE_W-1:0] m);
        logic [WORD_W-1:0] w;
        w = '0;
        w[MODE_W-1:0] = m;
        w[POS_F] = 1'b1;
        w[POS_I] = 1'b1;
        w[POS_A] = 1'b1;
        return w;
    endfunction

    function automatic psr_state_t split_word(input logic [WORD_W-1:0] word);
        psr_state_t s;
        s.flags = word & FLAG_MASK;
        s.main  = word & ~FLAG_MASK;
        return s;
    endfunction

endpackage

// File: rtl/psr_chg_unit.sv
module psr_chg_unit
    import psr_pkg::*;
(
    input  logic [WORD_W-1:0] cur_word,
    input  logic [IMM_W-1:0]  imm,
    input  logic              nmfi_cfg,
    output logic [WORD_W-1:0] next_word
);

    chg_cmd_t cmd;
    logic     privileged;

    assign cmd        = chg_cmd_t'(imm);
    assign privileged = !mode_is_user(cur_word);

    always_comb begin
        next_word = cur_word;
        if (privileged) begin
            if (cmd.enable) begin
                if (cmd.sel_f) next_word[POS_F] = 1'b0;
                if (cmd.sel_i) next_word[POS_I] = 1'b0;
                if (cmd.sel_a) next_word[POS_A] = 1'b0;
            end else begin
                if (cmd.sel_f && !nmfi_cfg) next_word[POS_F] = 1'b1;
                if (cmd.sel_i) next_word[POS_I] = 1'b1;
                if (cmd.sel_a) next_word[POS_A] = 1'b1;
            end
            if (cmd.set_mode) next_word[MODE_W-1:0] = cmd.mode;
        end
    end

endmodule

// File: rtl/psr_lane_merge.sv
module psr_lane_merge #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int TOT_W = LANE_W * LANES
) (
    input  logic [TOT_W-1:0] cur_word,
    input  logic [TOT_W-1:0] wr_data,
    input  logic [LANES-1:0] byte_en,
    output logic [TOT_W-1:0] merged
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged[k*LANE_W +: LANE_W] = byte_en[k] ? wr_data[k*LANE_W +: LANE_W]
                                                       : cur_word[k*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/psr_read_view.sv
module psr_read_view
    import psr_pkg::*;
(
    input  psr_state_t        state,
    output logic [WORD_W-1:0] combined,
    output logic [WORD_W-1:0] visible
);

    assign combined = state.flags | state.main;
    assign visible  = combined & READ_MASK;

endmodule

// File: rtl/psr_ctrl_unit.sv
module psr_ctrl_unit
    import psr_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = MODE_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic [IMM_W-1:0]  imm,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  byte_en,
    input  logic              nmfi_cfg,
    output logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] rd_data
);

    localparam logic [WORD_W-1:0] RST_WORD = reset_word(RESET_MODE);

    psr_state_t        state_q;
    psr_state_t        state_d;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] chg_word;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] end_word;
    logic [WORD_W-1:0] next_word;
    psr_op_e           op;

    assign op = psr_op_e'(op_sel);

    psr_read_view u_view (
        .state    (state_q),
        .combined (cur_word),
        .visible  (rd_data)
    );

    psr_chg_unit u_chg (
        .cur_word  (cur_word),
        .imm       (imm),
        .nmfi_cfg  (nmfi_cfg),
        .next_word (chg_word)
    );

    psr_lane_merge #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_merge (
        .cur_word (cur_word),
        .wr_data  (wr_data),
        .byte_en  (byte_en),
        .merged   (wr_word)
    );

    always_comb begin
        end_word        = cur_word;
        end_word[POS_E] = imm[0];
    end

    always_comb begin
        next_word = cur_word;
        if (op_valid) begin
            unique case (op)
                OP_WRITE:    next_word = wr_word;
                OP_CHGSTATE: next_word = chg_word;
                OP_ENDIAN:   next_word = end_word;
                default:     next_word = cur_word;
            endcase
        end
        state_d = split_word(next_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= split_word(RST_WORD);
        end else begin
            state_q <= state_d;
        end
    end

    assign status_word = cur_word;

endmodule

// File: rtl/psr_ctrl_checker.sv
module psr_ctrl_checker
    import psr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [1:0]        op_sel,
    input logic [IMM_W-1:0]  imm,
    input logic              nmfi_cfg,
    input logic [WORD_W-1:0] status_word
);

    logic chg_priv;
    assign chg_priv = op_valid && op_sel == 2'b01 && status_word[4:0] != MODE_USER;

    assert_user_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b01 && status_word[4:0] == MODE_USER) |=> $stable(status_word));

    assert_enable_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (chg_priv && imm[9] && imm[6]) |=> !status_word[POS_I]);

    assert_disable_set_R5: assert property (@(posedge clk) disable iff (rst)
        (chg_priv && !imm[9] && imm[7]) |=> status_word[POS_A]);

    assert_nmfi_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (chg_priv && !imm[9] && imm[5] && nmfi_cfg) |=> status_word[POS_F] == $past(status_word[POS_F]));

    assert_mode_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b01 && !imm[8]) |=> status_word[4:0] == $past(status_word[4:0]));

    assert_flags_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel != 2'b00) |=> (status_word & FLAG_MASK) == $past(status_word & FLAG_MASK));

    assert_endian_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b10) |=> status_word[POS_E] == $past(imm[0]));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_sel == 2'b11) |=> $stable(status_word));

endmodule

bind psr_ctrl_unit psr_ctrl_checker u_psr_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_sel      (op_sel),
    .imm         (imm),
    .nmfi_cfg    (nmfi_cfg),
    .status_word (status_word)
);

// File: tb/psr_ctrl_unit_bench.sv
module psr_ctrl_unit_bench;

    localparam logic [31:0] RMASK = 32'hF8FF_03DF;

    typedef struct packed {
        logic        vld;
        logic [1:0]  op;
        logic [9:0]  imm;
        logic [31:0] wd;
        logic [3:0]  be;
        logic        nmfi;
        logic [31:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 16;
    // chained from reset value 0x000001D3
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b01, 10'h2E0, 32'h0, 4'h0, 1'b0, 32'h0000_0013, "R4"},  // enable clears F,I,A
        '{1'b1, 2'b01, 10'h020, 32'h0, 4'h0, 1'b1, 32'h0000_0013, "R5"},  // nmfi blocks F set
        '{1'b1, 2'b01, 10'h060, 32'h0, 4'h0, 1'b0, 32'h0000_00D3, "R5"},  // disable sets F,I
        '{1'b1, 2'b01, 10'h01F, 32'h0, 4'h0, 1'b0, 32'h0000_00D3, "R6"},  // no mode request
        '{1'b1, 2'b01, 10'h11F, 32'h0, 4'h0, 1'b0, 32'h0000_00DF, "R6"},  // mode switch
        '{1'b1, 2'b00, 10'h000, 32'hA5A5_5AFF, 4'b1000, 1'b0, 32'hA500_00DF, "R7"},
        '{1'b1, 2'b00, 10'h000, 32'h1234_5678, 4'b0101, 1'b0, 32'hA534_0078, "R7"},
        '{1'b1, 2'b10, 10'h001, 32'h0, 4'h0, 1'b0, 32'hA534_0278, "R9"},
        '{1'b1, 2'b01, 10'h220, 32'h0, 4'h0, 1'b1, 32'hA534_0238, "R8"},  // flags kept, F cleared
        '{1'b1, 2'b01, 10'h110, 32'h0, 4'h0, 1'b0, 32'hA534_0230, "R6"},  // into user mode
        '{1'b1, 2'b01, 10'h1DF, 32'h0, 4'h0, 1'b0, 32'hA534_0230, "R3"},  // user: ignored
        '{1'b1, 2'b10, 10'h000, 32'h0, 4'h0, 1'b0, 32'hA534_0030, "R9"},  // endian in user
        '{1'b1, 2'b00, 10'h000, 32'h0000_00D3, 4'b0001, 1'b0, 32'hA534_00D3, "R7"},
        '{1'b1, 2'b11, 10'h2E0, 32'hFFFF_FFFF, 4'hF, 1'b0, 32'hA534_00D3, "R10"},
        '{1'b0, 2'b01, 10'h2E0, 32'h0, 4'h0, 1'b0, 32'hA534_00D3, "R10"},
        '{1'b1, 2'b01, 10'h190, 32'h0, 4'h0, 1'b0, 32'hA534_01D0, "R3"}   // A set + user switch
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_sel;
    logic [9:0]  imm;
    logic [31:0] wr_data;
    logic [3:0]  byte_en;
    logic        nmfi_cfg;
    logic [31:0] status_word;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    psr_ctrl_unit u_psr_ctrl_unit (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .op_sel      (op_sel),
        .imm         (imm),
        .wr_data     (wr_data),
        .byte_en     (byte_en),
        .nmfi_cfg    (nmfi_cfg),
        .status_word (status_word),
        .rd_data     (rd_data)
    );

    task automatic check(input logic [23:0] tag, input logic [31:0] exp);
        total++;
        if (status_word !== exp) begin
            bad++;
            $display("FAIL %s status actual=%08h expected=%08h", tag, status_word, exp);
        end
        total++;
        if (rd_data !== (exp & RMASK)) begin
            bad++;
            $display("FAIL R2 read actual=%08h expected=%08h", rd_data, exp & RMASK);
        end
    endtask

    task automatic issue(input logic v, input logic [1:0] o, input logic [9:0] im,
                         input logic [31:0] wd, input logic [3:0] be, input logic nm);
        @(negedge clk);
        op_valid = v; op_sel = o; imm = im; wr_data = wd; byte_en = be; nmfi_cfg = nm;
        @(posedge clk);
        #1;
        op_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_sel = 2'b00; imm = '0;
        wr_data = '0; byte_en = '0; nmfi_cfg = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1", 32'h0000_01D3);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].vld, VECS[i].op, VECS[i].imm, VECS[i].wd, VECS[i].be, VECS[i].nmfi);
            check(VECS[i].tag, VECS[i].exp);
        end

        // R3: next command in user mode after the combined switch is ignored
        issue(1'b1, 2'b01, 10'h2E0, 32'h0, 4'h0, 1'b0);
        check("R3", 32'hA534_01D0);

        // R1: reset mid-run restores the reset word and clears flags
        do_reset();
        check("R1", 32'h0000_01D3);

        // R4: enable path clears F even with nmfi configured
        issue(1'b1, 2'b01, 10'h220, 32'h0, 4'h0, 1'b1);
        check("R4", 32'h0000_0193);

        // R7: full-width write, then no lanes enabled
        issue(1'b1, 2'b00, 10'h0, 32'hFFFF_FFFF, 4'hF, 1'b0);
        check("R7", 32'hFFFF_FFFF);
        issue(1'b1, 2'b00, 10'h0, 32'h0, 4'h0, 1'b0);
        check("R7", 32'hFFFF_FFFF);

        // R8: change-state leaves flag bits; mode 11111 privileged, disable none + mode 10011
        issue(1'b1, 2'b01, 10'h113, 32'h0, 4'h0, 1'b0);
        check("R8", 32'hFFFF_FFF3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule